// File: doc/BRIEF.md
# Privileged Instruction Permission Gate

This block decides whether an instruction that has already been decoded may run, given the current processor mode and privilege state. The decoder raises a one-cycle check strobe together with a 3-bit instruction class. Alongside it come the protected-mode flag, the current privilege level, the I/O privilege level and the system-management state. One clock later the gate returns a registered result pulse. The pulse either grants execution or names a fault vector: 6 for invalid opcode, 13 for general protection.

The gate only classifies and reports. Instruction decoding, exception delivery and microcode sequencing stay with the surrounding pipeline. When a class meets both an invalid-opcode condition and a privilege condition, the invalid-opcode outcome is the one reported.

Top module: `priv_gate`

## Requirements
- R1: A synchronous reset drives `res_vld_o`, `res_ok_o` and `res_vec_o` to 0 on the next clock edge.
- R2: Each cycle with `chk_i` high produces exactly one result cycle with `res_vld_o` high on the following edge. A cycle without a strobe gives `res_vld_o`=0, `res_ok_o`=0 and `res_vec_o`=0 on the next edge.
- R3: The class codes are 0 plain, 1 protected-only, 2 ring-0-only, 3 I/O-sensitive, 4 system-management, 5 real-mode setup, and 6 and 7 reserved. Class 0 is always granted.
- R4: Class 1 faults with vector 6 when `prot_i`=0. It is granted when `prot_i`=1, at any privilege level.
- R5: Class 2 faults with vector 13 when `prot_i`=1 and `cpl_i`>0. It is granted when `cpl_i`=0, and it is always granted when `prot_i`=0.
- R6: Class 3 faults with vector 13 when `prot_i`=1 and `cpl_i` is numerically greater than `iopl_i`. It is granted when `cpl_i`≤`iopl_i`, and it is always granted when `prot_i`=0.
- R7: Class 4 is granted, in either mode, only when all of these hold: `smi_en_i`=1, `rng3_sz_i` is nonzero, `cpl_i`=0, and `smac_i`=1 or `in_smi_i`=1. Otherwise it faults with vector 6, never 13.
- R8: Class 5 is granted when `prot_i`=0, whatever `cpl_i` is. When `prot_i`=1 it faults with vector 13 if `cpl_i`>0 and is granted if `cpl_i`=0.
- R9: Classes 6 and 7 fault with vector 6 in any mode and at any privilege level. Vector 6 outranks vector 13.
- R10: In a result cycle, a grant shows as `res_ok_o`=1 with `res_vec_o`=0. A fault shows as `res_ok_o`=0 with `res_vec_o` set to 6 or 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| chk_i | input | 1 | One-cycle check strobe |
| cls_i | input | 3 | Instruction class code |
| prot_i | input | 1 | 1 = protected mode, 0 = real mode |
| cpl_i | input | 2 | Current privilege level (0 is most privileged) |
| iopl_i | input | 2 | I/O privilege level |
| smi_en_i | input | 1 | System-management interrupt enabled |
| rng3_sz_i | input | RSZ_W (4) | Size field of address range 3 |
| smac_i | input | 1 | System-management access control bit |
| in_smi_i | input | 1 | Executing inside a system-management handler |
| res_vld_o | output | 1 | Result pulse, one cycle after the strobe |
| res_ok_o | output | 1 | Execution granted |
| res_vec_o | output | VEC_W (8) | Fault vector, 0 when granted or idle |

## Verification
The bench targets the places where a comparison sits on an edge. The I/O check with `cpl_i` equal to `iopl_i` must grant; a design that used ≥ would report vector 13 there. In the system-management gate, each of the four conditions is dropped one at a time, and the two alternatives (control bit set, or running inside a handler) are each tried alone. A gate that tested only one alternative would wrongly fault. A system-management attempt at ring 1 in protected mode must give vector 6 and not 13, and reserved classes at ring 3 must give 6; a reversed priority would show 13 in both. Real-mode cases with `cpl_i`=3 on the privileged classes catch a gate that applies ring checks outside protected mode. Back-to-back strobes and idle cycles catch a missing or stretched result pulse.

// File: rtl/priv_gate.sv
module priv_gate #(
  parameter int VEC_W  = 8,
  parameter int RSZ_W  = 4,
  parameter int UD_VEC = 6,
  parameter int GP_VEC = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             chk_i,
  input  logic [2:0]       cls_i,
  input  logic             prot_i,
  input  logic [1:0]       cpl_i,
  input  logic [1:0]       iopl_i,
  input  logic             smi_en_i,
  input  logic [RSZ_W-1:0] rng3_sz_i,
  input  logic             smac_i,
  input  logic             in_smi_i,
  output logic             res_vld_o,
  output logic             res_ok_o,
  output logic [VEC_W-1:0] res_vec_o
);

  localparam logic [2:0] C_PLAIN = 3'd0;
  localparam logic [2:0] C_PROT  = 3'd1;
  localparam logic [2:0] C_RING0 = 3'd2;
  localparam logic [2:0] C_IOSEN = 3'd3;
  localparam logic [2:0] C_SMM   = 3'd4;
  localparam logic [2:0] C_RINIT = 3'd5;

  localparam logic [VEC_W-1:0] V_UD = VEC_W'(UD_VEC);
  localparam logic [VEC_W-1:0] V_GP = VEC_W'(GP_VEC);

  logic cpl_nz, io_viol, smm_ok, rsvd, ud, gp;
  logic [VEC_W-1:0] vec_d;

  assign cpl_nz  = |cpl_i;
  assign io_viol = cpl_i > iopl_i;
  assign smm_ok  = smi_en_i & (|rng3_sz_i) & ~cpl_nz & (smac_i | in_smi_i);
  assign rsvd    = cls_i > C_RINIT;

  assign ud = rsvd
            | (cls_i == C_PROT && !prot_i)
            | (cls_i == C_SMM  && !smm_ok);

  assign gp = prot_i & ( (cls_i == C_RING0 && cpl_nz)
                       | (cls_i == C_IOSEN && io_viol)
                       | (cls_i == C_RINIT && cpl_nz) );

  assign vec_d = ud ? V_UD : (gp ? V_GP : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_vld_o <= 1'b0;
      res_ok_o  <= 1'b0;
      res_vec_o <= '0;
    end else begin
      res_vld_o <= chk_i;
      res_ok_o  <= chk_i & ~ud & ~gp;
      res_vec_o <= chk_i ? vec_d : '0;
    end
  end

  assert_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    chk_i |=> res_vld_o);
  assert_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !chk_i |=> (!res_vld_o && !res_ok_o && res_vec_o == '0));
  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (!res_vld_o && !res_ok_o && res_vec_o == '0));
  assert_form_R10: assert property (@(posedge clk) disable iff (rst)
    res_vld_o |-> (res_ok_o ? (res_vec_o == '0)
                            : (res_vec_o == V_UD || res_vec_o == V_GP)));
  assert_realprot_R4: assert property (@(posedge clk) disable iff (rst)
    (chk_i && cls_i == C_PROT && !prot_i) |=> (!res_ok_o && res_vec_o == V_UD));
  assert_ring0_R5: assert property (@(posedge clk) disable iff (rst)
    (chk_i && cls_i == C_RING0 && prot_i && cpl_i != 2'd0) |=> res_vec_o == V_GP);
  assert_iopl_R6: assert property (@(posedge clk) disable iff (rst)
    (chk_i && cls_i == C_IOSEN && prot_i && cpl_i > iopl_i) |=> res_vec_o == V_GP);
  assert_smmring_R7: assert property (@(posedge clk) disable iff (rst)
    (chk_i && cls_i == C_SMM && cpl_i != 2'd0) |=> res_vec_o == V_UD);
  assert_rinit_R8: assert property (@(posedge clk) disable iff (rst)
    (chk_i && cls_i == C_RINIT && !prot_i) |=> res_ok_o);
  assert_rsvd_R9: assert property (@(posedge clk) disable iff (rst)
    (chk_i && cls_i > C_RINIT) |=> res_vec_o == V_UD);
  assert_plain_R3: assert property (@(posedge clk) disable iff (rst)
    (chk_i && cls_i == C_PLAIN) |=> res_ok_o);

endmodule

// File: tb/priv_gate_tb.sv
module priv_gate_tb;
  logic clk = 1'b0;
  logic rst, chk;
  logic [2:0] cls;
  logic prot, smi_en, smac, in_smi;
  logic [1:0] cpl, iopl;
  logic [3:0] rsz;
  logic vld, ok;
  logic [7:0] vec;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  priv_gate u_dut (
    .clk(clk), .rst(rst), .chk_i(chk), .cls_i(cls), .prot_i(prot),
    .cpl_i(cpl), .iopl_i(iopl), .smi_en_i(smi_en), .rng3_sz_i(rsz),
    .smac_i(smac), .in_smi_i(in_smi),
    .res_vld_o(vld), .res_ok_o(ok), .res_vec_o(vec)
  );

  // {req[3:0], cls[2:0], prot, cpl[1:0], iopl[1:0], smi_en, rsz[3:0], smac, in_smi, ok, vec[7:0]}
  localparam int N = 22;
  localparam logic [27:0] TBL [N] = '{
    {4'd3, 3'd0,1'b0,2'd3,2'd0,1'b0,4'd0,1'b0,1'b0, 1'b1,8'd0},
    {4'd3, 3'd0,1'b1,2'd3,2'd0,1'b0,4'd0,1'b0,1'b0, 1'b1,8'd0},
    {4'd4, 3'd1,1'b0,2'd0,2'd0,1'b0,4'd0,1'b0,1'b0, 1'b0,8'd6},
    {4'd4, 3'd1,1'b1,2'd3,2'd0,1'b0,4'd0,1'b0,1'b0, 1'b1,8'd0},
    {4'd5, 3'd2,1'b1,2'd1,2'd3,1'b0,4'd0,1'b0,1'b0, 1'b0,8'd13},
    {4'd5, 3'd2,1'b1,2'd0,2'd0,1'b0,4'd0,1'b0,1'b0, 1'b1,8'd0},
    {4'd5, 3'd2,1'b0,2'd3,2'd0,1'b0,4'd0,1'b0,1'b0, 1'b1,8'd0},
    {4'd6, 3'd3,1'b1,2'd2,2'd1,1'b0,4'd0,1'b0,1'b0, 1'b0,8'd13},
    {4'd6, 3'd3,1'b1,2'd2,2'd2,1'b0,4'd0,1'b0,1'b0, 1'b1,8'd0},
    {4'd6, 3'd3,1'b1,2'd0,2'd3,1'b0,4'd0,1'b0,1'b0, 1'b1,8'd0},
    {4'd6, 3'd3,1'b0,2'd3,2'd0,1'b0,4'd0,1'b0,1'b0, 1'b1,8'd0},
    {4'd7, 3'd4,1'b1,2'd0,2'd0,1'b1,4'd2,1'b1,1'b0, 1'b1,8'd0},
    {4'd7, 3'd4,1'b0,2'd0,2'd0,1'b1,4'd1,1'b0,1'b1, 1'b1,8'd0},
    {4'd7, 3'd4,1'b1,2'd0,2'd0,1'b1,4'd2,1'b0,1'b0, 1'b0,8'd6},
    {4'd7, 3'd4,1'b1,2'd0,2'd0,1'b1,4'd0,1'b1,1'b1, 1'b0,8'd6},
    {4'd7, 3'd4,1'b1,2'd0,2'd0,1'b0,4'd8,1'b1,1'b1, 1'b0,8'd6},
    {4'd9, 3'd4,1'b1,2'd1,2'd3,1'b1,4'd8,1'b1,1'b1, 1'b0,8'd6},
    {4'd8, 3'd5,1'b0,2'd3,2'd0,1'b0,4'd0,1'b0,1'b0, 1'b1,8'd0},
    {4'd8, 3'd5,1'b1,2'd2,2'd3,1'b0,4'd0,1'b0,1'b0, 1'b0,8'd13},
    {4'd8, 3'd5,1'b1,2'd0,2'd0,1'b0,4'd0,1'b0,1'b0, 1'b1,8'd0},
    {4'd9, 3'd6,1'b1,2'd3,2'd0,1'b0,4'd0,1'b0,1'b0, 1'b0,8'd6},
    {4'd9, 3'd7,1'b0,2'd0,2'd0,1'b1,4'd1,1'b1,1'b1, 1'b0,8'd6}
  };

  task automatic check(input string req, input logic v, input logic o,
                       input logic [7:0] e_vec, input logic e_v, input logic e_o);
    checks++;
    if (v !== e_v || o !== e_o || vec !== e_vec) begin
      fails++;
      $display("FAIL %s: got vld=%0b ok=%0b vec=%0d, expected vld=%0b ok=%0b vec=%0d",
               req, v, o, vec, e_v, e_o, e_vec);
    end
  endtask

  task automatic drive(input logic [27:0] e);
    cls = e[23:21]; prot = e[20]; cpl = e[19:18]; iopl = e[17:16];
    smi_en = e[15]; rsz = e[14:11]; smac = e[10]; in_smi = e[9];
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; chk = 1'b0; drive('0);
    repeat (3) @(negedge clk);
    check("R1 reset", vld, ok, 8'd0, 1'b0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R2 idle", vld, ok, 8'd0, 1'b0, 1'b0);

    for (int i = 0; i < N; i++) begin
      drive(TBL[i]);
      chk = 1'b1;
      @(negedge clk);
      chk = 1'b0;
      check($sformatf("R%0d row %0d (R10 form)", TBL[i][27:24], i),
            vld, ok, TBL[i][7:0], 1'b1, TBL[i][8]);
      @(negedge clk);
      check("R2 single pulse", vld, ok, 8'd0, 1'b0, 1'b0);
    end

    // R2 back-to-back strobes: fault then grant
    drive(TBL[2]); chk = 1'b1;
    @(negedge clk);
    check("R2 b2b first", vld, ok, 8'd6, 1'b1, 1'b0);
    drive(TBL[0]);
    @(negedge clk);
    check("R2 b2b second", vld, ok, 8'd0, 1'b1, 1'b1);
    chk = 1'b0;
    @(negedge clk);
    check("R2 b2b end", vld, ok, 8'd0, 1'b0, 1'b0);

    // R1 reset overrides a pending strobe
    drive(TBL[4]); chk = 1'b1; rst = 1'b1;
    @(negedge clk);
    check("R1 reset with strobe", vld, ok, 8'd0, 1'b0, 1'b0);
    chk = 1'b0; rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", vld, ok, 8'd0, 1'b0, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule